// File: doc/BRIEF.md
# E3 Receive Alarm Interrupt Controller

This block sits behind the receive framer of an E3 line interface and turns its raw alarm indications into interrupt status that a local processor can poll or take as an interrupt. It watches the recovered bit stream for loss of signal and the per-frame remote-defect bit for the far-end receive failure alarm (filtered over three or five frames). It also takes an alarm-indication-signal level from upstream logic and per-frame parity-error and alignment-error flags.

Each alarm keeps a current state, readable at any time, and an event bit that is set whenever that state changes in either direction. The parity and alignment flags set event bits directly. Event bits clear when their register is read, and a single interrupt line is raised while any enabled event bit is set. Reads use a two-bit address with a one-cycle read strobe. Read data is combinational from the address, and the clear takes effect at the clock edge that ends the read cycle.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: Loss of signal is declared at the clock edge that accepts the 32nd consecutive valid zero bit; cycles with `bit_vld` low change no count. Loss of signal is 0 after reset.
- R2: While loss of signal is active, it ends at the edge that accepts the 32nd consecutive valid bit with no run of four zeros inside the window; the fourth zero of any run restarts the window.
- R3: The far-end failure state toggles when `frm_ferf` differs from it in N consecutive frame strobes, N = 3 when `cfg_five` is 0 and N = 5 when it is 1; a matching frame restarts the run.
- R4: A change of `cfg_five` restarts the far-end run count without changing the far-end state.
- R5: Loss of signal, alarm indication and far-end failure each set their event bit on both the start and the end of the condition. Address 1 holds LOS change at bit 1 and AIS change at bit 0. Address 2 holds far-end change at bit 3.
- R6: A frame strobe with `frm_bip_err` set sets bit 2 of address 2.
- R7: A frame strobe with `frm_fas_err` set sets bit 1 of address 2.
- R8: A read of address 1 or 2 clears that register's event bits after the read cycle. An event arriving in the read cycle stays set. Unused bits and address 3 read 0.
- R9: Address 0 reads the current states without clearing anything: bit 4 LOS, bit 3 AIS (one cycle after `ais_in`), bit 2 far-end failure, all other bits 0.
- R10: `irq` is high while any event bit is set whose enable is set. The enable bits of `irq_en` are: [4] LOS, [3] AIS, [2] far-end, [1] parity, [0] alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Recovered bit valid strobe |
| bit_in | input | 1 | Recovered data bit |
| frm_stb | input | 1 | One cycle per received frame |
| frm_ferf | input | 1 | Received far-end failure bit of this frame |
| frm_bip_err | input | 1 | Frame received with parity mismatch |
| frm_fas_err | input | 1 | Frame alignment pattern in error |
| ais_in | input | 1 | Alarm indication detected level |
| cfg_five | input | 1 | Far-end filter length: 0 three frames, 1 five frames |
| irq_en | input | 5 | Per-event interrupt enables |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
A wrong loss-of-signal or far-end run count shows at the ports as a state bit at address 0 that flips one or more bits or frames early or late. It is seen at the first negative edge after the boundary bit or frame. The bench probes both sides of every boundary (31/32 bits, N-1/N frames), so an off-by-one cannot hide. A lost or stuck event bit shows on the next read of its register and on `irq` in the same cycle. The read-collision and config-change cases expose clear-over-set and stale-count mistakes on the first read after them.

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq #(
  parameter int LOS_DECL = 32,
  parameter int LOS_CLR  = 32,
  parameter int LOS_RUN  = 4,
  parameter int N_SHORT  = 3,
  parameter int N_LONG   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       frm_stb,
  input  logic       frm_ferf,
  input  logic       frm_bip_err,
  input  logic       frm_fas_err,
  input  logic       ais_in,
  input  logic       cfg_five,
  input  logic [4:0] irq_en,
  input  logic       rd_stb,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int CW = $clog2((LOS_DECL > LOS_CLR ? LOS_DECL : LOS_CLR) + 1);
  localparam int RW = $clog2(LOS_RUN + 1);
  localparam int FW = $clog2(N_LONG + 1);

  logic          los, los_n, ais_q, ferf, ferf_n, cfg_q;
  logic [CW-1:0] cnt, cnt_n;
  logic [RW-1:0] run, run_n;
  logic [FW-1:0] fcnt, fcnt_n, nsel;
  logic [4:0]    ev, ev_set, ev_clr;

  always_comb begin
    los_n = los;
    cnt_n = cnt;
    run_n = run;
    if (bit_vld) begin
      run_n = bit_in ? '0 : (run == RW'(LOS_RUN) ? run : run + 1'b1);
      if (!los) begin
        cnt_n = bit_in ? '0 : cnt + 1'b1;
        if (!bit_in && cnt == CW'(LOS_DECL - 1)) begin
          los_n = 1'b1;
          cnt_n = '0;
        end
      end else if (run_n == RW'(LOS_RUN)) begin
        cnt_n = '0;
      end else if (cnt == CW'(LOS_CLR - 1)) begin
        los_n = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  assign nsel = cfg_five ? FW'(N_LONG) : FW'(N_SHORT);

  always_comb begin
    ferf_n = ferf;
    fcnt_n = fcnt;
    if (cfg_five != cfg_q) begin
      fcnt_n = '0;
    end else if (frm_stb) begin
      if (frm_ferf == ferf) begin
        fcnt_n = '0;
      end else if (fcnt == nsel - 1'b1) begin
        ferf_n = ~ferf;
        fcnt_n = '0;
      end else begin
        fcnt_n = fcnt + 1'b1;
      end
    end
  end

  assign ev_set = {los_n ^ los, ais_in ^ ais_q, ferf_n ^ ferf,
                   frm_stb & frm_bip_err, frm_stb & frm_fas_err};
  assign ev_clr = {{2{rd_stb && rd_addr == 2'd1}}, {3{rd_stb && rd_addr == 2'd2}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los   <= 1'b0;
      cnt   <= '0;
      run   <= '0;
      ferf  <= 1'b0;
      fcnt  <= '0;
      cfg_q <= 1'b0;
      ais_q <= 1'b0;
      ev    <= '0;
    end else begin
      los   <= los_n;
      cnt   <= cnt_n;
      run   <= run_n;
      ferf  <= ferf_n;
      fcnt  <= fcnt_n;
      cfg_q <= cfg_five;
      ais_q <= ais_in;
      ev    <= (ev & ~ev_clr) | ev_set;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {3'b000, los, ais_q, ferf, 2'b00};
      2'd1:    rd_data = {6'b0, ev[4], ev[3]};
      2'd2:    rd_data = {4'b0, ev[2], ev[1], ev[0], 1'b0};
      default: rd_data = 8'h00;
    endcase
  end

  assign irq = |(ev & irq_en);

  p_los_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(bit_vld && !bit_in));
  p_los_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(bit_vld));
  p_ferf_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_stb |=> $stable(ferf));
  p_cfg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_five != cfg_q) |=> $stable(ferf));
  p_los_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(los) |-> ev[4]);
  p_ais_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais_q) |-> ev[3]);
  p_ferf_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ferf) |-> ev[2]);
  p_bip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stb && frm_bip_err |=> ev[1]);
  p_fas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_stb && frm_fas_err |=> ev[0]);
  p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_addr == 2'd2 && !frm_stb && cfg_five == cfg_q |=> ev[2:0] == 3'b000);
endmodule

// File: tb/e3_rx_alarm_irq_bench.sv
module e3_rx_alarm_irq_bench;
  logic clk = 0, rst_n = 0;
  logic bit_vld = 0, bit_in = 0, frm_stb = 0, frm_ferf = 0, frm_bip_err = 0, frm_fas_err = 0;
  logic ais_in = 0, cfg_five = 0, rd_stb = 0, irq;
  logic [4:0] irq_en = 5'h1f;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  e3_rx_alarm_irq u_e3_rx_alarm_irq (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_vld = 0; frm_stb = 0; ais_in = 0; cfg_five = 0; rd_stb = 0; irq_en = 5'h1f;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; rd_stb = 1; #1 d = rd_data;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_vld = 1;
    @(negedge clk); bit_vld = 0;
  endtask

  task automatic send_frm(input logic f, input logic bip, input logic fas);
    frm_ferf = f; frm_bip_err = bip; frm_fas_err = fas; frm_stb = 1;
    @(negedge clk); frm_stb = 0; frm_bip_err = 0; frm_fas_err = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    peek(0, d); chk("R9 reset state", d, 8'h00);
    peek(1, d); chk("R5 reset ist1", d, 8'h00);
    peek(2, d); chk("R5 reset ist2", d, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_los_declare();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < 31; i++) send_bit(0);
    @(negedge clk); @(negedge clk);
    peek(0, d); chk("R1 31 zeros no LOS", d, 8'h00);
    send_bit(1);
    for (int i = 0; i < 31; i++) send_bit(0);
    peek(0, d); chk("R1 restart after one", d, 8'h00);
    send_bit(0);
    peek(0, d); chk("R1 LOS on 32nd zero", d, 8'h10);
    rd(1, d); chk("R5 LOS start event", d, 8'h02);
    peek(1, d); chk("R8 ist1 cleared", d, 8'h00);
    peek(0, d); chk("R9 state read keeps", d, 8'h10);
  endtask

  task automatic t_los_clear();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < 32; i++) send_bit(0);
    rd(1, d);
    for (int i = 0; i < 20; i++) send_bit(1);
    for (int i = 0; i < 4; i++) send_bit(0);
    for (int i = 0; i < 31; i++) send_bit(1);
    peek(0, d); chk("R2 window restarted by 4 zeros", d, 8'h10);
    send_bit(1);
    peek(0, d); chk("R2 LOS ends at 32 clean bits", d, 8'h00);
    rd(1, d); chk("R5 LOS end event", d, 8'h02);
    for (int i = 0; i < 32; i++) send_bit(0);
    for (int i = 0; i < 31; i++) send_bit((i % 4) == 0);
    peek(0, d); chk("R2 zero-run-3 pattern 31 bits", d, 8'h10);
    send_bit(0);
    peek(0, d); chk("R2 zero-run-3 pattern clears", d, 8'h00);
  endtask

  task automatic t_ferf();
    logic [7:0] d;
    do_reset();
    send_frm(1, 0, 0); send_frm(1, 0, 0);
    peek(0, d); chk("R3 two frames no FERF", d, 8'h00);
    send_frm(1, 0, 0);
    peek(0, d); chk("R3 FERF after 3", d, 8'h04);
    rd(2, d); chk("R5 FERF start event bit3", d, 8'h08);
    send_frm(0, 0, 0); send_frm(0, 0, 0); send_frm(1, 0, 0);
    send_frm(0, 0, 0); send_frm(0, 0, 0);
    peek(0, d); chk("R3 interrupted run holds", d, 8'h04);
    send_frm(0, 0, 0);
    peek(0, d); chk("R3 FERF cleared after 3", d, 8'h00);
    rd(2, d); chk("R5 FERF end event", d, 8'h08);
    cfg_five = 1; @(negedge clk);
    for (int i = 0; i < 4; i++) send_frm(1, 0, 0);
    peek(0, d); chk("R3 four frames in 5 mode", d, 8'h00);
    send_frm(1, 0, 0);
    peek(0, d); chk("R3 FERF after 5", d, 8'h04);
  endtask

  task automatic t_cfg_change();
    logic [7:0] d;
    do_reset();
    send_frm(1, 0, 0); send_frm(1, 0, 0);
    cfg_five = 1; @(negedge clk);
    send_frm(1, 0, 0); send_frm(1, 0, 0);
    peek(0, d); chk("R4 count restarted at change", d, 8'h00);
    cfg_five = 0; @(negedge clk);
    peek(0, d); chk("R4 state kept across change", d, 8'h00);
    send_frm(1, 0, 0); send_frm(1, 0, 0);
    peek(0, d); chk("R4 two after second change", d, 8'h00);
    send_frm(1, 0, 0);
    peek(0, d); chk("R4 declares on third", d, 8'h04);
  endtask

  task automatic t_errors_ais();
    logic [7:0] d;
    do_reset();
    send_frm(0, 1, 0);
    peek(2, d); chk("R6 parity event bit2", d, 8'h04);
    send_frm(0, 0, 1);
    rd(2, d); chk("R7 alignment event bit1", d, 8'h06);
    ais_in = 1; @(negedge clk);
    peek(0, d); chk("R9 AIS state bit3", d, 8'h08);
    rd(1, d); chk("R5 AIS start event", d, 8'h01);
    ais_in = 0; @(negedge clk);
    rd(1, d); chk("R5 AIS end event", d, 8'h01);
    rd(3, d); chk("R8 address 3 reads 0", d, 8'h00);
  endtask

  task automatic t_collision_irq();
    logic [7:0] d;
    do_reset();
    irq_en = 5'h00;
    send_frm(0, 1, 0);
    #1 chk("R10 masked no irq", {7'b0, irq}, 8'h00);
    irq_en = 5'b00010;
    #1 chk("R10 enabled irq", {7'b0, irq}, 8'h01);
    irq_en = 5'b00001;
    #1 chk("R10 other enable no irq", {7'b0, irq}, 8'h00);
    irq_en = 5'b00010;
    frm_ferf = 0; frm_bip_err = 0; frm_fas_err = 1; frm_stb = 1;
    rd_addr = 2; rd_stb = 1; #1 d = rd_data;
    chk("R8 read data before collision", d, 8'h04);
    @(negedge clk); rd_stb = 0; frm_stb = 0; frm_fas_err = 0;
    peek(2, d); chk("R8 new event survives read", d, 8'h02);
    #1 chk("R10 irq drops after clear", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_los_declare();
        t_los_clear();
        t_ferf();
        t_cfg_change();
        t_errors_ais();
        t_collision_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule